// File: doc/BRIEF.md
# Dual-Input Timer Capture Unit

This block is a free-running up-counter with two capture/compare registers, driven from two external trigger inputs. The counter advances once for each rising phase of a count clock. The count clock is a slow level signal that is synchronous to the system clock and is produced elsewhere. Each trigger input is synchronized and then filtered, so that only a level held across several count-clock cycles counts as an edge. When an accepted edge matches the edge mode programmed for that input, the current count is latched into a register on the next falling phase of the count clock. The matching interrupt pulse follows on the next rising phase.

Register 1 always follows input B. A source-select bit picks where register 0 is loaded from: either input A, or the edge of B with the opposite polarity. With that bit set, a valid edge on B also raises the register-0 interrupt without loading register 0, so B can act as a plain interrupt source. Either register can be put in compare mode. In compare mode it stops capturing and instead pulses its interrupt when the counter reaches the stored value. A read that collides with a capture into the same register is flagged.

Top module: `dual_capture_timer`

## Requirements
- R1: The counter is CW bits wide (default 16) and increments once per rising phase of `cclk`. It wraps from all-ones to zero, and `ovf` pulses for one cycle with `count` reading zero at the wrap.
- R2: Each trigger passes through a two-flop synchronizer. A level change is accepted only if the new level is seen at three consecutive rising phases of `cclk`. A pulse seen at only one or two of them is ignored.
- R3: The 2-bit edge mode of each input is encoded as 00 = falling, 01 = rising, 10 = disabled, 11 = both. An accepted change of the other polarity has no effect.
- R4: With `src_sel` = 0, register 0 captures on valid edges of A. Register 1 always captures on valid edges of B.
- R5: The value latched is the count after the rising phase at which the edge was accepted. It is loaded on the next falling phase of `cclk`. The interrupt pulses for one system cycle on the rising phase after that.
- R6: With `src_sel` = 1, register 0 is loaded by the B edge of opposite polarity to B's mode: a rising edge when B is in falling mode, a falling edge when B is in rising mode, and no edge for the other modes. A valid B edge raises `irq0` without loading register 0.
- R7: With `src_sel` = 1 and A's mode set to both edges, register 0 never captures and its opposite-edge interrupt is suppressed. The B valid-edge `irq0` still fires.
- R8: A register in compare mode (`cmp_mode[i]` = 1) neither captures nor raises a trigger interrupt. Its interrupt pulses one cycle after the count update that makes `count` equal to the register value.
- R9: `wr_en` with `wr_sel` writes `wr_data` into the selected register. A capture in the same cycle takes priority.
- R10: A read (`rd_en`, `rd_sel`) returns the register value one cycle later in `rd_data`. If a capture loads that register in the same cycle, `rd_unsure` is 1 and `rd_data` holds either the old value or the new one.
- R11: After reset the count, both registers, `rd_data`, `rd_unsure`, `ovf` and both interrupts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cclk | input | 1 | Count clock level, synchronous to clk |
| trig_a | input | 1 | Raw trigger input A |
| trig_b | input | 1 | Raw trigger input B |
| edge_a | input | 2 | Valid-edge mode of A |
| edge_b | input | 2 | Valid-edge mode of B |
| src_sel | input | 1 | Register-0 source: 0 = A, 1 = opposite edge of B |
| cmp_mode | input | 2 | Per-register compare mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register index for write |
| wr_data | input | CW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Register index for read |
| rd_data | output | CW | Read data, one cycle after rd_en |
| rd_unsure | output | 1 | Read collided with a capture |
| count | output | CW | Current counter value |
| ovf | output | 1 | Counter wrap pulse |
| irq0 | output | 1 | Register-0 interrupt pulse |
| irq1 | output | 1 | Register-1 interrupt pulse |

## Verification
The bench drives pulses that last one and two count-clock cycles. A filter that counted one stage short would turn these into captures and spurious interrupts. It compares the latched value and the interrupt's count-clock cycle against the rise at which the trigger changed, so a capture taken at the wrong phase would be off by one count. With `src_sel` set it checks that a B edge raises `irq0` while register 0 keeps its old contents, and that the both-edges setting of A stops the opposite-edge load. A design that rerouted or suppressed these wrongly would load register 0 or drop an interrupt. It also checks that a B trigger in compare mode leaves register 1 untouched, and that a read issued in the capture cycle is flagged.

// File: rtl/dual_capture_timer.sv
module dual_capture_timer #(
  parameter int CW   = 16,
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cclk,
  input  logic          trig_a,
  input  logic          trig_b,
  input  logic [1:0]    edge_a,
  input  logic [1:0]    edge_b,
  input  logic          src_sel,
  input  logic [1:0]    cmp_mode,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  output logic          rd_unsure,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          irq0,
  output logic          irq1
);
  localparam int FCW = $clog2(FILT + 1);

  function automatic logic pick(input logic [1:0] m, input logic r, input logic f);
    case (m)
      2'b00:   pick = f;
      2'b01:   pick = r;
      2'b11:   pick = r | f;
      default: pick = 1'b0;
    endcase
  endfunction

  logic          cclk_q, rise_d;
  logic          c_rise, c_fall;
  logic [SYNC-1:0] sync_q [2];
  logic [1:0]    lvl, seen, acc, rose, fell;
  logic [FCW-1:0] fcnt [2];
  logic [1:0]    pend_cap, pend_irq, arm;
  logic [CW-1:0] creg [2];
  logic [1:0]    load, cap_ev, int_ev, fire;
  logic          hit_a, hit_b, rev_b;

  assign c_rise = cclk & ~cclk_q;
  assign c_fall = ~cclk & cclk_q;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      seen[i] = sync_q[i][SYNC-1];
      acc[i]  = c_rise && (seen[i] != lvl[i]) && (fcnt[i] == FCW'(FILT - 1));
      rose[i] = acc[i] & seen[i];
      fell[i] = acc[i] & ~seen[i];
    end
  end

  assign hit_a  = pick(edge_a, rose[0], fell[0]);
  assign hit_b  = pick(edge_b, rose[1], fell[1]);
  assign rev_b  = (edge_b == 2'b00 && rose[1]) || (edge_b == 2'b01 && fell[1]);
  assign cap_ev = {hit_b, src_sel ? (rev_b && edge_a != 2'b11) : hit_a};
  assign int_ev = {hit_b, cap_ev[0] | (src_sel & hit_b)};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      load[i] = c_fall && pend_cap[i] && !cmp_mode[i];
      fire[i] = (c_rise && arm[i] && !cmp_mode[i]) ||
                (cmp_mode[i] && rise_d && count == creg[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q    <= 1'b0;
      rise_d    <= 1'b0;
      lvl       <= '0;
      pend_cap  <= '0;
      pend_irq  <= '0;
      arm       <= '0;
      count     <= '0;
      ovf       <= 1'b0;
      irq0      <= 1'b0;
      irq1      <= 1'b0;
      rd_data   <= '0;
      rd_unsure <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        sync_q[i] <= '0;
        fcnt[i]   <= '0;
        creg[i]   <= '0;
      end
    end else begin
      cclk_q <= cclk;
      rise_d <= c_rise;
      ovf    <= c_rise && (&count);
      if (c_rise) count <= count + 1'b1;
      irq0 <= fire[0];
      irq1 <= fire[1];
      for (int i = 0; i < 2; i++) begin
        sync_q[i] <= {sync_q[i][SYNC-2:0], (i == 0) ? trig_a : trig_b};
        if (seen[i] == lvl[i]) fcnt[i] <= '0;
        else if (acc[i]) begin
          lvl[i]  <= seen[i];
          fcnt[i] <= '0;
        end else if (c_rise) fcnt[i] <= fcnt[i] + 1'b1;

        if (c_fall) begin
          pend_cap[i] <= 1'b0;
          pend_irq[i] <= 1'b0;
          arm[i]      <= pend_irq[i];
        end else if (c_rise) begin
          arm[i] <= 1'b0;
        end
        if (cap_ev[i] && !cmp_mode[i]) pend_cap[i] <= 1'b1;
        if (int_ev[i] && !cmp_mode[i]) pend_irq[i] <= 1'b1;

        if (load[i]) creg[i] <= count;
        else if (wr_en && wr_sel == i[0]) creg[i] <= wr_data;
      end
      rd_unsure <= rd_en && load[rd_sel];
      if (rd_en) rd_data <= creg[rd_sel];
    end
  end

  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> count == '0);
  a_r5_irq0_phase: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> ($past(c_rise) || $past(rise_d)));
  a_r5_irq0_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |=> !irq0);
  a_r5_irq1_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |=> !irq1);
  a_r5_load_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(creg[1]) |-> ($past(c_fall) || $past(wr_en)));
  a_r7_both_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && edge_a == 2'b11 && !pend_cap[0]) |=> !pend_cap[0]);
  a_r8_cmp_hold0: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_mode[0] && !(wr_en && !wr_sel)) |-> $stable(creg[0]));
  a_r8_cmp_hold1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_mode[1] && !(wr_en && wr_sel)) |-> $stable(creg[1]));
  a_r10_unsure_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unsure |-> $past(rd_en));
endmodule

// File: tb/test_dual_capture_timer.sv
module test_dual_capture_timer;
  localparam int CW = 10;
  localparam int M  = 1 << CW;

  typedef struct { int rise; int val; } item_t;

  logic clk = 0, rst_n = 0, cclk = 0, trig_a = 0, trig_b = 0;
  logic [1:0] edge_a = 2'b01, edge_b = 2'b01, cmp_mode = 2'b00;
  logic src_sel = 0, wr_en = 0, wr_sel = 0, rd_en = 0, rd_sel = 0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data, count;
  logic rd_unsure, ovf, irq0, irq1;

  int tests = 0, fails = 0, rises = 0, ovf_seen = 0;
  int e0 = 0, e1 = 0;
  bit run = 0;
  item_t q0[$], q1[$];

  dual_capture_timer #(.CW(CW)) i_dual_capture_timer (
    .clk(clk), .rst_n(rst_n), .cclk(cclk), .trig_a(trig_a), .trig_b(trig_b),
    .edge_a(edge_a), .edge_b(edge_b), .src_sel(src_sel), .cmp_mode(cmp_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .rd_unsure(rd_unsure), .count(count),
    .ovf(ovf), .irq0(irq0), .irq1(irq1));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int ch, input int rise, input int val);
    item_t it;
    it.rise = rise;
    it.val  = val % M;
    if (ch == 0) q0.push_back(it); else q1.push_back(it);
  endtask

  initial begin
    wait (run);
    forever begin
      repeat (4) @(negedge clk);
      cclk = ~cclk;
      if (cclk) rises++;
    end
  end

  always @(negedge clk) begin
    if (run) begin
      logic [1:0] fired;
      item_t it;
      fired = {irq1, irq0};
      if (ovf) begin
        ovf_seen++;
        check(rises % M == 0 && count == 0, "R1 wrap", int'(count), 0);
      end
      for (int c = 0; c < 2; c++) begin
        if (fired[c]) begin
          if ((c == 0 ? q0.size() : q1.size()) == 0) begin
            check(0, c == 0 ? "R2/R3 spurious irq0" : "R2/R3 spurious irq1", 1, 0);
          end else begin
            it = (c == 0) ? q0.pop_front() : q1.pop_front();
            check(rises == it.rise, "R5 irq cycle", rises, it.rise);
            rd_sel = c[0];
            rd_en  = 1;
            @(negedge clk);
            rd_en = 0;
            check(int'(rd_data) == it.val, "R4/R6/R8 register value", int'(rd_data), it.val);
          end
        end
      end
    end
  end

  task automatic edge_in(input int which, input bit lvl, output int base);
    @(negedge cclk);
    @(negedge clk);
    if (which == 0) trig_a = lvl; else trig_b = lvl;
    base = rises;
  endtask

  task automatic settle();
    repeat (6) @(negedge cclk);
  endtask

  task automatic quiet(input string req);
    check(q0.size() == 0 && q1.size() == 0, req, q0.size() + q1.size(), 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n, old;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(count == 0 && ovf == 0 && irq0 == 0 && irq1 == 0, "R11 reset outputs", int'(count), 0);
    rd_en = 1; rd_sel = 1;
    @(negedge clk);
    rd_en = 0;
    check(rd_data == 0 && rd_unsure == 0, "R11 reset register", int'(rd_data), 0);
    run = 1;

    // R4 R5: A rising edge, source A
    edge_in(0, 1, n); e0 = n + 3; push(0, n + 4, e0); settle();
    // R3: falling edge ignored in rising mode
    edge_in(0, 0, n); settle();
    quiet("R3 rising mode");
    // R3: falling mode
    edge_a = 2'b00;
    edge_in(0, 1, n); settle();
    edge_in(0, 0, n); e0 = n + 3; push(0, n + 4, e0); settle();
    // R3: both edges
    edge_a = 2'b11;
    edge_in(0, 1, n); e0 = n + 3; push(0, n + 4, e0); settle();
    edge_in(0, 0, n); e0 = n + 3; push(0, n + 4, e0); settle();
    quiet("R3 both edges");
    // R2: short pulses of one and two count-clock cycles
    edge_in(0, 1, n); @(negedge cclk); @(negedge clk); trig_a = 0; settle();
    edge_in(0, 1, n); repeat (2) @(negedge cclk); @(negedge clk); trig_a = 0; settle();
    quiet("R2 short pulse");
    // R4: register 1 from B
    edge_in(1, 1, n); e1 = n + 3; push(1, n + 4, e1); settle();
    edge_in(1, 0, n); settle();
    quiet("R4 B capture");
    // R6: source select 1
    src_sel = 1; edge_a = 2'b00;
    edge_in(1, 1, n); e1 = n + 3; push(0, n + 4, e0); push(1, n + 4, e1); settle();
    edge_in(1, 0, n); e0 = n + 3; push(0, n + 4, e0); settle();
    quiet("R6 rerouted source");
    // R7: A both with select 1
    edge_a = 2'b11;
    edge_in(1, 1, n); e1 = n + 3; push(0, n + 4, e0); push(1, n + 4, e1); settle();
    edge_in(1, 0, n); settle();
    quiet("R7 both-edge block");
    // R8 R9: compare mode on register 1
    src_sel = 0; edge_a = 2'b01; cmp_mode = 2'b10;
    @(negedge clk);
    n = rises + 30;
    wr_en = 1; wr_sel = 1; wr_data = CW'(n % M);
    @(negedge clk);
    wr_en = 0;
    e1 = n % M; push(1, n, e1);
    edge_in(1, 1, old);
    while (rises < n + 1) @(negedge clk);
    cmp_mode = 2'b00;
    settle();
    quiet("R8 compare match");
    // R10: read colliding with capture
    old = e0;
    edge_in(0, 1, n); e0 = n + 3; push(0, n + 4, e0);
    while (rises < n + 3) @(negedge clk);
    @(negedge cclk);
    rd_sel = 0; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    check(rd_unsure == 1, "R10 collision flag", int'(rd_unsure), 1);
    check(int'(rd_data) == old || int'(rd_data) == e0 % M, "R10 collision data", int'(rd_data), e0 % M);
    settle();
    quiet("R10 follow-up irq");
    // R1: run past the wrap
    while (rises < M + 6) @(negedge clk);
    @(negedge cclk); @(negedge clk);
    check(int'(count) == rises % M, "R1 count value", int'(count), rises % M);
    check(ovf_seen == 1, "R1 single wrap", ovf_seen, 1);
    quiet("R1 end");
    summary();
    $finish;
  end
endmodule